// File: doc/BRIEF.md
# Scrolling Fetch Address Generator

This block produces the memory address a bitplane display controller uses to pull screen words. It keeps a programmable screen base, a running refresh counter and a per-line skip amount, all reachable through a small byte-wide register bus. A frame-start pulse copies the base into the counter. A line-start pulse arms a line of fetches. Each accepted fetch strobe advances the counter by one word. The last fetch of a line also adds the skip amount, so software can describe a virtual screen wider than the one shown.

When the fine-scroll value is non-zero, every line carries one more fetch group than the visible width needs. That group supplies the pixels pushed in from the right edge. A group is four words in the four-plane mode and one word in the single-plane mode. Software lowers the skip amount by one group to make up for it. Vertical scrolling is done by rewriting the base during blanking. The counter can also be rewritten at any moment, including in the middle of a frame.

Top module: `scroll_fetch_addr`

## Requirements
- R1: After reset the counter, base, skip and control registers read zero, `mem_addr` is zero and `line_busy` is low.
- R2: The register select picks the byte seen on `reg_rdata`. 0, 1 and 2 are counter address bits [21:16], [15:8] and [7:0]. 3, 4 and 5 are the same three ranges of the base. 6 is the skip in words. 7 is control, with bit 4 as the single-plane flag and bits [3:0] as the scroll value. The top byte shows 6 bits with upper zeros, and address bit 0 always reads 0.
- R3: A write to a counter byte changes that byte on the next cycle and leaves the other bytes alone. It wins over a frame load and over a fetch step in the same cycle; that strobe still uses up one fetch of the line.
- R4: `frame_start` loads the counter from the base on the next cycle, and the base may sit on any word boundary. A base write does not move the counter until the next `frame_start`.
- R5: While a line is armed (`line_busy` high), each `fetch_stb` advances `mem_addr` by 2. Strobes are ignored when no line is armed, and `mem_addr` holds when nothing acts on it.
- R6: `line_start` arms a line of `LO_GROUPS`×4 words in four-plane mode, or `MONO_WORDS` words in single-plane mode. `line_busy` falls after the last of them.
- R7: The last fetch of a line adds the skip value, counted in words, on top of its own one-word step.
- R8: A non-zero scroll value lengthens every armed line by one group: 4 words in four-plane mode and 1 word in single-plane mode.
- R9: With skip and scroll both zero, consecutive lines continue a plain linear buffer.
- R10: `frame_start` disarms the line and beats `line_start` and `fetch_stb`. A `fetch_stb` in the same cycle as `line_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Byte read from the selected register |
| frame_start | input | 1 | Frame start pulse, loads counter from base |
| line_start | input | 1 | Line start pulse, arms a line of fetches |
| fetch_stb | input | 1 | One word fetched |
| mem_addr | output | 22 | Byte address of the next word to fetch |
| line_busy | output | 1 | Fetches of the current line remain |

## Verification
Lines are run in four-plane mode with scroll and skip zero, with skip alone, and with scroll plus a reduced skip. This separates the normal line length, the skip add and the extra group. Single-plane lines with and without scroll confirm that the group size follows the mode. Extra strobes after each line show that over-fetch is ignored. Collisions are then driven on purpose: a counter write against a strobe, a frame pulse against a strobe, and a line pulse against a strobe. A base change made mid-frame shows that it is deferred until the next frame load.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    localparam int ADDR_W  = 22;
    localparam int WORD_W  = ADDR_W - 1;
    localparam int HI_W    = ADDR_W - 16;
    localparam int GROUP_4 = 4;

    typedef enum logic [2:0] {
        SEL_CNT_HI  = 3'd0,
        SEL_CNT_MID = 3'd1,
        SEL_CNT_LO  = 3'd2,
        SEL_BAS_HI  = 3'd3,
        SEL_BAS_MID = 3'd4,
        SEL_BAS_LO  = 3'd5,
        SEL_SKIP    = 3'd6,
        SEL_CTRL    = 3'd7
    } sel_e;

    typedef struct packed {
        logic       mono;
        logic [3:0] scroll;
    } ctrl_t;

    function automatic int words_per_line(ctrl_t c, int lo_groups, int mono_words);
        int n;
        if (c.mono) n = mono_words + ((c.scroll != 4'd0) ? 1 : 0);
        else        n = lo_groups * GROUP_4 + ((c.scroll != 4'd0) ? GROUP_4 : 0);
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] put_byte(logic [WORD_W-1:0] w,
                                                   logic [1:0] part, logic [7:0] d);
        logic [WORD_W-1:0] r;
        r = w;
        case (part)
            2'd0:    r[WORD_W-1:15] = d[HI_W-1:0];
            2'd1:    r[14:7]        = d;
            default: r[6:0]         = d[7:1];
        endcase
        return r;
    endfunction

    function automatic logic [7:0] get_byte(logic [WORD_W-1:0] w, logic [1:0] part);
        logic [7:0] r;
        case (part)
            2'd0:    r = 8'({w[WORD_W-1:15]});
            2'd1:    r = w[14:7];
            default: r = {w[6:0], 1'b0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sfa_regs.sv
module sfa_regs
    import sfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    input  logic [WORD_W-1:0] cnt_word,
    output logic [WORD_W-1:0] base_word,
    output logic [7:0]        skip,
    output ctrl_t             ctrl,
    output logic [7:0]        rdata
);
    sel_e s;
    assign s = sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_word <= '0;
            skip      <= '0;
            ctrl      <= '0;
        end else if (we) begin
            case (s)
                SEL_BAS_HI:  base_word <= put_byte(base_word, 2'd0, wdata);
                SEL_BAS_MID: base_word <= put_byte(base_word, 2'd1, wdata);
                SEL_BAS_LO:  base_word <= put_byte(base_word, 2'd2, wdata);
                SEL_SKIP:    skip      <= wdata;
                SEL_CTRL:    ctrl      <= ctrl_t'(wdata[4:0]);
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (s)
            SEL_CNT_HI:  rdata = get_byte(cnt_word, 2'd0);
            SEL_CNT_MID: rdata = get_byte(cnt_word, 2'd1);
            SEL_CNT_LO:  rdata = get_byte(cnt_word, 2'd2);
            SEL_BAS_HI:  rdata = get_byte(base_word, 2'd0);
            SEL_BAS_MID: rdata = get_byte(base_word, 2'd1);
            SEL_BAS_LO:  rdata = get_byte(base_word, 2'd2);
            SEL_SKIP:    rdata = skip;
            default:     rdata = {3'b000, ctrl};
        endcase
    end

    AST_SKIP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && s == SEL_SKIP) |=> skip == $past(wdata)); // R2
endmodule

// File: rtl/sfa_line_seq.sv
module sfa_line_seq
    import sfa_pkg::*;
#(
    parameter int LO_GROUPS  = 20,
    parameter int MONO_WORDS = 40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    input  logic  line_start,
    input  logic  fetch_stb,
    input  ctrl_t ctrl,
    output logic  step,
    output logic  line_last,
    output logic  busy
);
    localparam int MAX_LO  = LO_GROUPS * GROUP_4 + GROUP_4;
    localparam int MAX_MO  = MONO_WORDS + 1;
    localparam int MAX_LEN = (MAX_LO > MAX_MO) ? MAX_LO : MAX_MO;
    localparam int REM_W   = $clog2(MAX_LEN + 1);

    logic [REM_W-1:0] rem;
    logic [REM_W-1:0] len;

    assign len       = REM_W'(words_per_line(ctrl, LO_GROUPS, MONO_WORDS));
    assign busy      = (rem != '0);
    assign step      = fetch_stb && !frame_start && !line_start && busy;
    assign line_last = step && (rem == REM_W'(1));

    always_ff @(posedge clk) begin
        if (rst)              rem <= '0;
        else if (frame_start) rem <= '0;
        else if (line_start)  rem <= len;
        else if (step)        rem <= rem - REM_W'(1);
    end

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        rem <= REM_W'(MAX_LEN)); // R6
    AST_LINE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start) |=> busy); // R6
    AST_FRAME_DISARM: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !busy); // R10
endmodule

// File: rtl/sfa_addr_ctr.sv
module sfa_addr_ctr
    import sfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    input  logic              frame_start,
    input  logic [WORD_W-1:0] base_word,
    input  logic              step,
    input  logic              line_last,
    input  logic [7:0]        skip,
    output logic [WORD_W-1:0] word
);
    logic cnt_wr;
    logic [WORD_W-1:0] inc;

    assign cnt_wr = we && (sel <= 3'd2);
    assign inc    = WORD_W'(1) + (line_last ? WORD_W'(skip) : '0);

    always_ff @(posedge clk) begin
        if (rst)              word <= '0;
        else if (cnt_wr)      word <= put_byte(word, sel[1:0], wdata);
        else if (frame_start) word <= base_word;
        else if (step)        word <= word + inc;
    end

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !cnt_wr) |=> word == $past(base_word)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (step && !line_last && !cnt_wr && !frame_start) |=> word == $past(word) + WORD_W'(1)); // R5
    AST_SKIP_ADD: assert property (@(posedge clk) disable iff (rst)
        (line_last && !cnt_wr && !frame_start) |=> word == $past(word) + WORD_W'(1) + WORD_W'($past(skip))); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !frame_start && !cnt_wr) |=> $stable(word)); // R5
    AST_WRITE_LOW: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 3'd2) |=> word[6:0] == $past(wdata[7:1])); // R3
endmodule

// File: rtl/scroll_fetch_addr.sv
module scroll_fetch_addr
    import sfa_pkg::*;
#(
    parameter int LO_GROUPS  = 20,
    parameter int MONO_WORDS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              fetch_stb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              line_busy
);
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] base_word;
    logic [7:0]        skip;
    ctrl_t             ctrl;
    logic              step;
    logic              line_last;

    sfa_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .cnt_word(word), .base_word(base_word), .skip(skip), .ctrl(ctrl),
        .rdata(reg_rdata)
    );

    sfa_line_seq #(.LO_GROUPS(LO_GROUPS), .MONO_WORDS(MONO_WORDS)) u_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
        .fetch_stb(fetch_stb), .ctrl(ctrl), .step(step), .line_last(line_last),
        .busy(line_busy)
    );

    sfa_addr_ctr u_ctr (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .frame_start(frame_start), .base_word(base_word), .step(step),
        .line_last(line_last), .skip(skip), .word(word)
    );

    assign mem_addr = {word, 1'b0};

    AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (fetch_stb && !line_busy && !reg_we && !frame_start) |=> $stable(mem_addr)); // R5
endmodule

// File: tb/tb_scroll_fetch_addr.sv
module tb_scroll_fetch_addr;
    localparam int CLK_PERIOD = 10;
    localparam int LOG = 20;
    localparam int MW  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic frame_start = 1'b0, line_start = 1'b0, fetch_stb = 1'b0;
    logic [7:0] reg_rdata;
    logic [21:0] mem_addr;
    logic line_busy;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string req = "R1";

    int m_cnt = 0, m_base = 0, m_skip = 0, m_scroll = 0, m_mono = 0, m_rem = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_fetch_addr #(.LO_GROUPS(LOG), .MONO_WORDS(MW)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .line_start(line_start), .fetch_stb(fetch_stb), .mem_addr(mem_addr),
        .line_busy(line_busy)
    );

    function automatic int put(int w, int part, int d);
        case (part)
            0: return (w & 32'h7FFF) | ((d & 8'h3F) << 15);
            1: return (w & ~(32'hFF << 7)) | ((d & 8'hFF) << 7);
            default: return (w & ~32'h7F) | ((d >> 1) & 8'h7F);
        endcase
    endfunction

    function automatic int get(int w, int part);
        case (part)
            0: return (w >> 15) & 8'h3F;
            1: return (w >> 7) & 8'hFF;
            default: return (w << 1) & 8'hFF;
        endcase
    endfunction

    function automatic int exp_rd(int sel);
        if (sel <= 2) return get(m_cnt, sel);
        if (sel <= 5) return get(m_base, sel - 3);
        if (sel == 6) return m_skip;
        return (m_mono << 4) | m_scroll;
    endfunction

    task automatic tick(bit we, int sel, int wd, bit fs, bit ls, bit stb);
        int len, step_ok;
        reg_we = we; reg_sel = 3'(sel); reg_wdata = 8'(wd);
        frame_start = fs; line_start = ls; fetch_stb = stb;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_base = 0; m_skip = 0; m_scroll = 0; m_mono = 0; m_rem = 0;
        end else begin
            len = m_mono ? MW + (m_scroll != 0) : LOG * 4 + ((m_scroll != 0) ? 4 : 0);
            step_ok = stb && !fs && !ls && (m_rem > 0);
            if (we && sel <= 2) m_cnt = put(m_cnt, sel, wd);
            else if (fs) m_cnt = m_base;
            else if (step_ok) m_cnt = (m_cnt + 1 + ((m_rem == 1) ? m_skip : 0)) & 32'h1FFFFF;
            if (fs) m_rem = 0;
            else if (ls) m_rem = len;
            else if (step_ok) m_rem = m_rem - 1;
            if (we && sel >= 3 && sel <= 5) m_base = put(m_base, sel - 3, wd);
            if (we && sel == 6) m_skip = wd & 8'hFF;
            if (we && sel == 7) begin m_scroll = wd & 4'hF; m_mono = (wd >> 4) & 1; end
        end
        @(negedge clk);
        vectors++;
        if (mem_addr !== 22'(m_cnt * 2)) begin
            miscompares++;
            $display("FAIL %s mem_addr got %h exp %h", req, mem_addr, 22'(m_cnt * 2));
        end
        if (line_busy !== (m_rem != 0)) begin
            miscompares++;
            $display("FAIL %s line_busy got %b exp %b", req, line_busy, (m_rem != 0));
        end
        if (reg_rdata !== 8'(exp_rd(sel))) begin
            miscompares++;
            $display("FAIL %s reg_rdata sel %0d got %h exp %h", req, sel, reg_rdata, 8'(exp_rd(sel)));
        end
    endtask

    task automatic wr(int sel, int d); tick(1, sel, d, 0, 0, 0); endtask
    task automatic idle(int sel); tick(0, sel, 0, 0, 0, 0); endtask
    task automatic line(int n); // arm a line then n strobes
        tick(0, 2, 0, 0, 1, 0);
        for (int i = 0; i < n; i++) tick(0, 2, 0, 0, 0, 1);
    endtask

    initial begin
        @(negedge clk);
        tick(0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        req = "R1"; for (int s = 0; s < 8; s++) idle(s);
        req = "R4"; wr(3, 8'h01); wr(4, 8'h23); wr(5, 8'h46);
        idle(2);
        tick(0, 2, 0, 1, 0, 0);
        req = "R2"; for (int s = 0; s < 8; s++) idle(s);
        req = "R5"; tick(0, 2, 0, 0, 0, 1); tick(0, 2, 0, 0, 0, 1);
        req = "R9"; line(LOG * 4 + 3); line(LOG * 4 + 2);
        req = "R7"; wr(6, 80); line(LOG * 4 + 2);
        req = "R8"; wr(7, 8'h05); wr(6, 76); line(LOG * 4 + 6);
        req = "R6"; wr(7, 8'h10); wr(6, 0); line(MW + 2);
        req = "R8"; wr(7, 8'h13); wr(6, 3); line(MW + 3);
        req = "R3"; tick(0, 2, 0, 0, 1, 0); tick(0, 2, 0, 0, 0, 1);
        tick(1, 2, 8'h7F, 0, 0, 1); tick(1, 1, 8'hA5, 0, 0, 1);
        tick(1, 0, 8'hFF, 1, 0, 1); idle(0); idle(1); idle(2);
        req = "R4"; wr(3, 8'h3F); wr(5, 8'hFE); tick(0, 2, 0, 0, 0, 1);
        idle(5); idle(3);
        req = "R10"; tick(0, 2, 0, 1, 1, 1); tick(0, 2, 0, 0, 1, 1);
        tick(0, 2, 0, 0, 0, 1); tick(0, 2, 0, 1, 0, 1); tick(0, 2, 0, 0, 0, 1);
        req = "R2"; for (int s = 0; s < 8; s++) idle(s);
        req = "R1"; rst = 1'b1; tick(0, 0, 0, 0, 0, 0); rst = 1'b0;
        for (int s = 0; s < 8; s++) idle(s);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule